// File: doc/BRIEF.md
# Program Image Segment Loader

This block turns a program image held in a byte-wide source memory into a loaded memory image. After a start pulse it reads a fixed header from source address 0. The header holds an identifying word, the address at which execution should begin, and the length of a descriptor table. The block then walks the descriptors one at a time. Each descriptor names a stretch of source bytes and the target address where those bytes must go, and the block copies that stretch one byte at a time.

Both memories are reached through simple request/acknowledge ports. A request stays asserted, with its address held steady, until the memory acknowledges it. Read data is taken in the cycle the acknowledge is seen. When the last byte of the last descriptor has been written, the block pulses a done flag and presents the execution start address for the instruction pointer. An image whose identifying word is wrong, or whose table is empty, stops the block with an error flag and leaves the target memory untouched.

Top module: `seg_loader`

## Requirements
- R1: After reset, done, error, rd_req and wr_req are 0 and entry_addr is 0.
- R2: If the four bytes at source 0..3 are not 0x4E,0x49,0x43,0x45 (the characters N,I,C,E in that order), error goes to 1 and stays at 1 until the next start. In that case no write request is made and done does not pulse.
- R3: The 32-bit value at source 0x04, read little-endian (lowest address is the least significant byte), appears on entry_addr and is held there after done.
- R4: If the 32-bit little-endian count at source 0x08 is zero, error goes to 1, no write request is made and done does not pulse.
- R5: Descriptor k starts at source 0x0C + 12*k. It holds three little-endian 32-bit fields: source offset at +0, byte count at +4 and target address at +8. Each source byte offset+i is written to target address+i.
- R6: Descriptors are processed in table order, so where target ranges overlap, the bytes of the later descriptor are the ones that remain.
- R7: Target bytes outside every descriptor's range are never written, even when segments lie megabytes apart.
- R8: A descriptor with a byte count of zero causes no write, and the block goes on to the next descriptor.
- R9: done is high for exactly one cycle after the final write acknowledge, and is never high together with error.
- R10: Once rd_req or wr_req is raised, it stays high with a stable address (and stable write data) until the matching acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse to begin loading; ignored while loading |
| rd_req | output | 1 | Source read request |
| rd_addr | output | 32 | Source byte address |
| rd_ack | input | 1 | Source read acknowledge, rd_data valid |
| rd_data | input | 8 | Source read byte |
| wr_req | output | 1 | Target write request |
| wr_addr | output | 32 | Target byte address |
| wr_data | output | 8 | Target write byte |
| wr_ack | input | 1 | Target write acknowledge |
| entry_addr | output | 32 | Start address for the instruction pointer |
| done | output | 1 | One-cycle pulse when loading completes |
| error | output | 1 | Image rejected; held until next start |

## Verification
The bench memories answer a request at the falling edge after they see it, so each byte costs at least two cycles per port. The exact finishing cycle therefore depends on the image. For that reason each scenario polls on falling edges for done or error under a cycle bound, rather than sampling at a fixed cycle. Once done is seen, the very next falling edge must show it low again, which confirms the single-cycle pulse one cycle after the copier's final acknowledge. Target contents and the write count are checked only after the flag appears, when no further write can arrive.

// File: rtl/seg_loader_pkg.sv
package seg_loader_pkg;
    localparam int unsigned ADDR_W    = 32;
    localparam int unsigned WORD_W    = 32;
    localparam logic [31:0] IMG_TAG   = 32'h4543_494E;
    localparam logic [31:0] OFS_ENTRY = 32'h0000_0004;
    localparam logic [31:0] OFS_COUNT = 32'h0000_0008;
    localparam logic [31:0] OFS_TABLE = 32'h0000_000C;
    localparam logic [31:0] DESC_LEN  = 32'd12;

    typedef enum logic [3:0] {
        LD_IDLE,
        LD_TAG,
        LD_ENTRY,
        LD_COUNT,
        LD_DSRC,
        LD_DLEN,
        LD_DDST,
        LD_COPY
    } ld_state_e;

    typedef enum logic [1:0] {
        CP_IDLE,
        CP_READ,
        CP_WRITE
    } cp_state_e;
endpackage

// File: rtl/sl_word_fetch.sv
module sl_word_fetch #(
    parameter int unsigned AW    = 32,
    parameter int unsigned BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [AW-1:0]     base,
    output logic              rd_req,
    output logic [AW-1:0]     rd_addr,
    input  logic              rd_ack,
    input  logic [7:0]        rd_data,
    output logic              word_vld,
    output logic [8*BYTES-1:0] word
);
    localparam int unsigned IW = (BYTES > 1) ? $clog2(BYTES) : 1;

    typedef struct packed {
        logic               active;
        logic [IW-1:0]      idx;
        logic [AW-1:0]      base;
        logic [8*BYTES-1:0] word;
        logic               vld;
    } wf_state_t;

    wf_state_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.vld = 1'b0;
        if (!s_q.active) begin
            if (go) begin
                s_d.active = 1'b1;
                s_d.idx    = '0;
                s_d.base   = base;
                s_d.word   = '0;
            end
        end else if (rd_ack) begin
            s_d.word[s_q.idx*8 +: 8] = rd_data;
            if (s_q.idx == IW'(BYTES-1)) begin
                s_d.active = 1'b0;
                s_d.vld    = 1'b1;
            end else begin
                s_d.idx = s_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_req   = s_q.active;
    assign rd_addr  = s_q.base + AW'(s_q.idx);
    assign word_vld = s_q.vld;
    assign word     = s_q.word;

    // R10
    fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));
endmodule

// File: rtl/sl_byte_copier.sv
module sl_byte_copier #(
    parameter int unsigned AW = 32,
    parameter int unsigned LW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] dst,
    input  logic [LW-1:0] len,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    input  logic          rd_ack,
    input  logic [7:0]    rd_data,
    output logic          wr_req,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    input  logic          wr_ack,
    output logic          fin
);
    import seg_loader_pkg::*;

    typedef struct packed {
        cp_state_e     st;
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [LW-1:0] len;
        logic [LW-1:0] cnt;
        logic [7:0]    data;
        logic          fin;
    } cp_t;

    cp_t c_d, c_q;

    always_comb begin
        c_d     = c_q;
        c_d.fin = 1'b0;
        unique case (c_q.st)
            CP_IDLE: if (go) begin
                c_d.src = src;
                c_d.dst = dst;
                c_d.len = len;
                c_d.cnt = '0;
                if (len == '0) c_d.fin = 1'b1;
                else           c_d.st  = CP_READ;
            end
            CP_READ: if (rd_ack) begin
                c_d.data = rd_data;
                c_d.st   = CP_WRITE;
            end
            CP_WRITE: if (wr_ack) begin
                c_d.cnt = c_q.cnt + 1'b1;
                if (c_q.cnt + 1'b1 == c_q.len) begin
                    c_d.st  = CP_IDLE;
                    c_d.fin = 1'b1;
                end else begin
                    c_d.st = CP_READ;
                end
            end
            default: c_d.st = CP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{st: CP_IDLE, default: '0};
        else        c_q <= c_d;
    end

    assign rd_req  = (c_q.st == CP_READ);
    assign rd_addr = c_q.src + AW'(c_q.cnt);
    assign wr_req  = (c_q.st == CP_WRITE);
    assign wr_addr = c_q.dst + AW'(c_q.cnt);
    assign wr_data = c_q.data;
    assign fin     = c_q.fin;

    // R10
    copy_wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));
    // R10
    copy_rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));
    // R5
    copy_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_req) |-> $past(rd_ack));
    // R8
    copy_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go && len == '0 && c_q.st == CP_IDLE) |=> !wr_req);
endmodule

// File: rtl/seg_loader.sv
module seg_loader #(
    parameter int unsigned AW = 32,
    parameter int unsigned CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    input  logic          rd_ack,
    input  logic [7:0]    rd_data,
    output logic          wr_req,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    input  logic          wr_ack,
    output logic [31:0]   entry_addr,
    output logic          done,
    output logic          error
);
    import seg_loader_pkg::*;

    localparam int unsigned FW = WORD_W;

    typedef struct packed {
        ld_state_e     st;
        logic [31:0]   entry;
        logic [CW-1:0] count;
        logic [CW-1:0] idx;
        logic [AW-1:0] tab;
        logic [AW-1:0] seg_src;
        logic [31:0]   seg_len;
        logic [AW-1:0] seg_dst;
        logic [AW-1:0] fbase;
        logic          fgo;
        logic          cgo;
        logic          done;
        logic          err;
    } ld_t;

    ld_t l_d, l_q;

    logic          f_rd_req, c_rd_req;
    logic [AW-1:0] f_rd_addr, c_rd_addr;
    logic          f_vld, c_fin;
    logic [FW-1:0] f_word;

    sl_word_fetch #(.AW(AW), .BYTES(FW/8)) u_fetch (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (l_q.fgo),
        .base     (l_q.fbase),
        .rd_req   (f_rd_req),
        .rd_addr  (f_rd_addr),
        .rd_ack   (rd_ack & f_rd_req),
        .rd_data  (rd_data),
        .word_vld (f_vld),
        .word     (f_word)
    );

    sl_byte_copier #(.AW(AW), .LW(32)) u_copy (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (l_q.cgo),
        .src     (l_q.seg_src),
        .dst     (l_q.seg_dst),
        .len     (l_q.seg_len),
        .rd_req  (c_rd_req),
        .rd_addr (c_rd_addr),
        .rd_ack  (rd_ack & c_rd_req),
        .rd_data (rd_data),
        .wr_req  (wr_req),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .wr_ack  (wr_ack),
        .fin     (c_fin)
    );

    assign rd_req  = f_rd_req | c_rd_req;
    assign rd_addr = c_rd_req ? c_rd_addr : f_rd_addr;

    always_comb begin
        l_d      = l_q;
        l_d.fgo  = 1'b0;
        l_d.cgo  = 1'b0;
        l_d.done = 1'b0;
        unique case (l_q.st)
            LD_IDLE: if (start) begin
                l_d.err   = 1'b0;
                l_d.fgo   = 1'b1;
                l_d.fbase = '0;
                l_d.st    = LD_TAG;
            end
            LD_TAG: if (f_vld) begin
                if (f_word != IMG_TAG) begin
                    l_d.err = 1'b1;
                    l_d.st  = LD_IDLE;
                end else begin
                    l_d.fgo   = 1'b1;
                    l_d.fbase = AW'(OFS_ENTRY);
                    l_d.st    = LD_ENTRY;
                end
            end
            LD_ENTRY: if (f_vld) begin
                l_d.entry = f_word;
                l_d.fgo   = 1'b1;
                l_d.fbase = AW'(OFS_COUNT);
                l_d.st    = LD_COUNT;
            end
            LD_COUNT: if (f_vld) begin
                if (f_word == '0) begin
                    l_d.err = 1'b1;
                    l_d.st  = LD_IDLE;
                end else begin
                    l_d.count = CW'(f_word);
                    l_d.idx   = '0;
                    l_d.tab   = AW'(OFS_TABLE);
                    l_d.fgo   = 1'b1;
                    l_d.fbase = AW'(OFS_TABLE);
                    l_d.st    = LD_DSRC;
                end
            end
            LD_DSRC: if (f_vld) begin
                l_d.seg_src = AW'(f_word);
                l_d.fgo     = 1'b1;
                l_d.fbase   = l_q.tab + AW'(4);
                l_d.st      = LD_DLEN;
            end
            LD_DLEN: if (f_vld) begin
                l_d.seg_len = f_word;
                l_d.fgo     = 1'b1;
                l_d.fbase   = l_q.tab + AW'(8);
                l_d.st      = LD_DDST;
            end
            LD_DDST: if (f_vld) begin
                l_d.seg_dst = AW'(f_word);
                l_d.cgo     = 1'b1;
                l_d.st      = LD_COPY;
            end
            LD_COPY: if (c_fin) begin
                if (l_q.idx + 1'b1 == l_q.count) begin
                    l_d.done = 1'b1;
                    l_d.st   = LD_IDLE;
                end else begin
                    l_d.idx   = l_q.idx + 1'b1;
                    l_d.tab   = l_q.tab + AW'(DESC_LEN);
                    l_d.fgo   = 1'b1;
                    l_d.fbase = l_q.tab + AW'(DESC_LEN);
                    l_d.st    = LD_DSRC;
                end
            end
            default: l_d.st = LD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) l_q <= '{st: LD_IDLE, default: '0};
        else        l_q <= l_d;
    end

    assign entry_addr = l_q.entry;
    assign done       = l_q.done;
    assign error      = l_q.err;

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9
    done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error));
    // R2
    err_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> !wr_req);
    // R10
    port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(f_rd_req && c_rd_req));
    // R3
    entry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(done) |-> $stable(entry_addr));
endmodule

// File: tb/seg_loader_bench.sv
module seg_loader_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        rd_req, wr_req;
    logic [31:0] rd_addr, wr_addr;
    logic        rd_ack = 1'b0;
    logic [7:0]  rd_data = 8'h00;
    logic [7:0]  wr_data;
    logic        wr_ack = 1'b0;
    logic [31:0] entry_addr;
    logic        done, error;

    int checks = 0;
    int fails  = 0;
    int wr_count = 0;
    int cycles = 0;

    logic [7:0] src [0:511];
    logic [7:0] tgt [logic [31:0]];

    localparam logic [7:0] SENT = 8'hA5;

    always #10 clk = ~clk;

    seg_loader u_seg_loader (
        .clk(clk), .rst_n(rst_n), .start(start),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
        .entry_addr(entry_addr), .done(done), .error(error)
    );

    always @(negedge clk) begin
        cycles <= cycles + 1;
        if (rd_ack) rd_ack <= 1'b0;
        else if (rd_req) begin
            rd_ack  <= 1'b1;
            rd_data <= src[rd_addr[8:0]];
        end
        if (wr_ack) wr_ack <= 1'b0;
        else if (wr_req) begin
            wr_ack <= 1'b1;
            tgt[wr_addr] = wr_data;
            wr_count <= wr_count + 1;
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        while (cycles < 150000) @(negedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic put32(int a, logic [31:0] v);
        for (int i = 0; i < 4; i++) src[a+i] = v[i*8 +: 8];
    endtask

    task automatic put_desc(int k, logic [31:0] o, logic [31:0] n, logic [31:0] l);
        put32(12 + 12*k, o);
        put32(16 + 12*k, n);
        put32(20 + 12*k, l);
    endtask

    task automatic clear_image();
        for (int i = 0; i < 512; i++) src[i] = 8'((i * 7) ^ 8'h5A);
        tgt.delete();
        put32(0, 32'h4543_494E);
    endtask

    function automatic logic [7:0] tget(logic [31:0] a);
        return tgt.exists(a) ? tgt[a] : 8'hXX;
    endfunction

    // runs the loader; returns 1 for done, 2 for error, 0 for timeout
    task automatic run(output int how, output logic pulse_low_next);
        wr_count = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        how = 0;
        pulse_low_next = 1'b0;
        for (int i = 0; i < 5000 && how == 0; i++) begin
            @(negedge clk);
            if (done) how = 1;
            else if (error) how = 2;
        end
        @(negedge clk);
        pulse_low_next = !done;
    endtask

    task automatic t_reset();
        chk("R1 done", {31'd0, done}, 32'd0);
        chk("R1 error", {31'd0, error}, 32'd0);
        chk("R1 rd_req", {31'd0, rd_req}, 32'd0);
        chk("R1 wr_req", {31'd0, wr_req}, 32'd0);
        chk("R1 entry", entry_addr, 32'd0);
    endtask

    task automatic t_basic();
        int how; logic low;
        clear_image();
        put32(4, 32'h1234_5678);
        put32(8, 32'd2);
        put_desc(0, 32'h30, 32'd5, 32'h0000_0100);
        put_desc(1, 32'h40, 32'd3, 32'h0070_0000);
        tgt[32'h0000_00FF] = SENT;
        tgt[32'h0000_0105] = SENT;
        tgt[32'h0070_0003] = SENT;
        run(how, low);
        chk("R9 done seen", how, 1);
        chk("R9 done one cycle", {31'd0, low}, 32'd1);
        chk("R3 entry", entry_addr, 32'h1234_5678);
        for (int i = 0; i < 5; i++) chk("R5 seg0 byte", tget(32'h100 + i), src[32'h30 + i]);
        for (int i = 0; i < 3; i++) chk("R7 far seg byte", tget(32'h70_0000 + i), src[32'h40 + i]);
        chk("R7 below seg0", tget(32'hFF), SENT);
        chk("R7 above seg0", tget(32'h105), SENT);
        chk("R7 above seg1", tget(32'h70_0003), SENT);
        chk("R7 write count", wr_count, 8);
        repeat (5) @(negedge clk);
        chk("R3 entry held", entry_addr, 32'h1234_5678);
        chk("R9 no writes after done", wr_count, 8);
    endtask

    task automatic t_overlap();
        int how; logic low;
        clear_image();
        put32(4, 32'hCAFE_0001);
        put32(8, 32'd2);
        put_desc(0, 32'h30, 32'd6, 32'h200);
        put_desc(1, 32'h50, 32'd2, 32'h202);
        run(how, low);
        chk("R6 done", how, 1);
        chk("R6 byte 200", tget(32'h200), src[32'h30]);
        chk("R6 byte 201", tget(32'h201), src[32'h31]);
        chk("R6 byte 202 later wins", tget(32'h202), src[32'h50]);
        chk("R6 byte 203 later wins", tget(32'h203), src[32'h51]);
        chk("R6 byte 204", tget(32'h204), src[32'h34]);
        chk("R6 byte 205", tget(32'h205), src[32'h35]);
        chk("R3 entry second image", entry_addr, 32'hCAFE_0001);
    endtask

    task automatic t_zero_size();
        int how; logic low;
        clear_image();
        put32(4, 32'h0000_0040);
        put32(8, 32'd3);
        put_desc(0, 32'h30, 32'd0, 32'h400);
        put_desc(1, 32'h60, 32'd2, 32'h300);
        put_desc(2, 32'h70, 32'd0, 32'h500);
        run(how, low);
        chk("R8 done", how, 1);
        chk("R8 write count", wr_count, 2);
        chk("R8 empty seg untouched", {31'd0, tgt.exists(32'h400)}, 32'd0);
        chk("R8 trailing empty untouched", {31'd0, tgt.exists(32'h500)}, 32'd0);
        chk("R8 middle seg byte", tget(32'h301), src[32'h61]);
    endtask

    task automatic t_bad_tag();
        int how; logic low;
        clear_image();
        src[3] = 8'h46;
        put32(4, 32'h1);
        put32(8, 32'd1);
        put_desc(0, 32'h30, 32'd4, 32'h600);
        run(how, low);
        chk("R2 error", how, 2);
        chk("R2 no writes", wr_count, 0);
        repeat (4) @(negedge clk);
        chk("R2 error held", {31'd0, error}, 32'd1);
        chk("R2 done low", {31'd0, done}, 32'd0);
    endtask

    task automatic t_zero_count();
        int how; logic low;
        clear_image();
        put32(4, 32'h2);
        put32(8, 32'd0);
        put_desc(0, 32'h30, 32'd4, 32'h600);
        run(how, low);
        chk("R4 error", how, 2);
        chk("R4 no writes", wr_count, 0);
        chk("R4 done low", {31'd0, done}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_basic();
        t_overlap();
        t_zero_size();
        t_bad_tag();
        t_zero_count();
        t_basic();
        summary();
    end
endmodule